// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Controller

This block is the home-node directory for a set of memory blocks in a multiprocessor that has no broadcast. Each block tracks its sharers with a small fixed set of pointer slots. Each slot holds a binary processor identifier and a valid flag. Each block also has one dirty flag that marks a single owner with write permission. The number of slots per block does not depend on the processor count. When a new reader finds every slot taken, one current sharer is chosen pseudorandomly and invalidated. The reader then takes its slot, so the slots behave like a small set-associative cache of processor identifiers.

Caches present read and write requests on a single request port. The controller serves one transaction at a time. It issues invalidations one at a time on its invalidate port and waits for the matching acknowledgement for each one. Only after every required acknowledgement has arrived does it grant the requester a copy (read) or a copy with write permission (write). A per-block busy flag and the ready output hold off any new request while a transaction is open.

Top module: `lp_dir_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `inv_valid` and `gnt_valid` are 0, and every block has no sharers and is clean.
- R2: A read to a block with a free slot and no other owner produces no invalidation. It produces a one-cycle grant with `gnt_write`=0, the requester's id and the block number in the cycle after the request is accepted.
- R3: A read from a processor that is already listed for the block allocates no new slot and sends no invalidation.
- R4: A read from an unlisted processor to a clean block whose slots are all valid sends exactly one invalidation, addressed to one current sharer. The grant is withheld until that sharer acknowledges. The reader then replaces only that sharer, and the other sharers stay listed.
- R5: A write invalidates every other listed sharer, one at a time in ascending slot order (slot 0 is filled first on allocation). It grants with `gnt_write`=1 only after the last acknowledgement.
- R6: After a write grant, the block is dirty with the writer as its only sharer. A further write by that writer is granted at once with no invalidation. A read by another processor first invalidates the writer and then leaves the block clean.
- R7: An acknowledgement whose processor id differs from the outstanding invalidation target is ignored: no grant and no new invalidation follow it.
- R8: While a transaction is open, `req_ready` is 0 and a presented request is not accepted, so it never produces a grant.
- R9: The victim on overflow is drawn from a free-running pseudorandom source that advances every cycle. Over repeated overflows both slot positions are chosen.
- R10: Blocks are independent: sharers or dirty state of one block never cause an invalidation for a request to another block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_pid | input | 4 | Requesting processor id |
| req_blk | input | 4 | Target block number |
| req_ready | output | 1 | Request accepted on this edge when valid |
| inv_valid | output | 1 | One-cycle invalidate pulse |
| inv_pid | output | 4 | Processor to invalidate |
| inv_blk | output | 4 | Block to invalidate |
| ack_valid | input | 1 | Invalidate acknowledgement present |
| ack_pid | input | 4 | Processor sending the acknowledgement |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_write | output | 1 | 1 = write permission granted |
| gnt_pid | output | 4 | Processor receiving the grant |
| gnt_blk | output | 4 | Block granted |

## Verification
A request that needs no invalidation is granted in the cycle right after its accepting edge. A request that needs invalidations shows its first invalidate pulse in that cycle instead. Each later invalidate pulse, or the final grant, appears in the cycle after the edge that registers the matching acknowledgement. The bench drives every input on a falling edge and samples outputs on the next falling edge after the edge that should produce them. It always sends an acknowledgement only in the waiting cycle after an invalidate pulse, so each expected pulse is checked in exactly the cycle it is due. The victim cannot be predicted from the ports, so checks on overflow accept either current sharer and track the survivor with a bench-side model.

// File: rtl/lpd_pkg.sv
// Package: shared types for the limited-pointer directory controller.
// Assumes: nothing beyond IEEE 1800-2017.
package lpd_pkg;
    // Transaction engine states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // waiting for a request
        ST_INV  = 2'd1,  // invalidate pulse is out
        ST_WAIT = 2'd2,  // waiting for the matching acknowledgement
        ST_GNT  = 2'd3   // grant pulse and directory update
    } eng_state_e;
endpackage

// File: rtl/lpd_lfsr.sv
// Module: free-running pseudorandom victim source.
// Purpose: an 8-bit maximal LFSR advances every cycle. Its value reduced
// modulo the slot count gives the victim slot index.
// Assumes: SLOTS >= 1. There is no per-block replacement state.
module lpd_lfsr #(
    parameter int SLOTS  = 2,
    parameter int SLOT_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] victim
);
    localparam int LW = 8;
    localparam logic [LW-1:0] SEED = 8'hA5;
    localparam logic [LW-1:0] SLOTS_L = LW'(SLOTS);

    logic [LW-1:0] lfsr_q;
    logic [LW-1:0] mod_val;

    // Advance the register every cycle (taps 8,6,5,4).
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= {lfsr_q[LW-2:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
    end

    // Reduce the state to a legal slot index.
    always_comb begin
        mod_val = lfsr_q % SLOTS_L;
        victim  = mod_val[SLOT_W-1:0];
    end

    // R9: the source never locks up in the all-zero state.
    a_r9_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != '0);
endmodule

// File: rtl/lpd_first_set.sv
// Module: lowest-index set-bit finder.
// Purpose: picks the next pending invalidation slot and the first free slot.
// Assumes: IW is wide enough to hold N-1.
module lpd_first_set #(
    parameter int N  = 2,
    parameter int IW = 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (vec[j]) idx = IW'(j);
        end
        any = |vec;
    end
endmodule

// File: rtl/lpd_entry_store.sv
// Module: per-block directory storage.
// Purpose: holds the pointer slots, slot valid bits, dirty bit and busy flag
// of every block. It has one combinational read port, one synchronous write
// port, and busy set and clear strobes.
// Assumes: the caller never writes and reads inconsistent blocks in one cycle.
module lpd_entry_store #(
    parameter int NBLK  = 16,
    parameter int NPTR  = 2,
    parameter int PID_W = 4,
    parameter int BLK_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BLK_W-1:0]       rd_blk,
    output logic [NPTR*PID_W-1:0]  rd_ptr,
    output logic [NPTR-1:0]        rd_vld,
    output logic                   rd_dirty,
    output logic                   rd_busy,
    input  logic                   wr_en,
    input  logic [BLK_W-1:0]       wr_blk,
    input  logic [NPTR*PID_W-1:0]  wr_ptr,
    input  logic [NPTR-1:0]        wr_vld,
    input  logic                   wr_dirty,
    input  logic                   set_busy,
    input  logic                   clr_busy,
    input  logic [BLK_W-1:0]       busy_blk
);
    logic [NPTR*PID_W-1:0] ptr_mem   [NBLK];
    logic [NPTR-1:0]       vld_mem   [NBLK];
    logic [NBLK-1:0]       dirty_mem;
    logic [NBLK-1:0]       busy_mem;
    logic                  wr_dup;

    // Read port: combinational view of one block.
    always_comb begin
        rd_ptr   = ptr_mem[rd_blk];
        rd_vld   = vld_mem[rd_blk];
        rd_dirty = dirty_mem[rd_blk];
        rd_busy  = busy_mem[rd_blk];
    end

    // Write port and reset: entries cleared, then updated at a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                ptr_mem[b] <= '0;
                vld_mem[b] <= '0;
            end
            dirty_mem <= '0;
        end else if (wr_en) begin
            ptr_mem[wr_blk]   <= wr_ptr;
            vld_mem[wr_blk]   <= wr_vld;
            dirty_mem[wr_blk] <= wr_dirty;
        end
    end

    // Busy flags: one per block, set on accept and cleared on grant.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_mem <= '0;
        else if (set_busy) busy_mem[busy_blk] <= 1'b1;
        else if (clr_busy) busy_mem[busy_blk] <= 1'b0;
    end

    // Duplicate detector on write data, for the assertion below.
    always_comb begin
        wr_dup = 1'b0;
        for (int j = 0; j < NPTR; j++) begin
            for (int k = j + 1; k < NPTR; k++) begin
                if (wr_vld[j] && wr_vld[k] &&
                    wr_ptr[j*PID_W +: PID_W] == wr_ptr[k*PID_W +: PID_W])
                    wr_dup = 1'b1;
            end
        end
    end

    // R6: a dirty entry is written with exactly one valid slot.
    a_r6_dirty_single: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dirty) |-> ($countones(wr_vld) == 1));
    // R3: no processor is listed twice in one entry.
    a_r3_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wr_dup);
    // R8: a block that is already busy is never opened again.
    a_r8_busy_once: assert property (@(posedge clk) disable iff (!rst_n)
        set_busy |-> !busy_mem[busy_blk]);
endmodule

// File: rtl/lp_dir_ctrl.sv
// Module: limited-pointer directory controller (top).
// Purpose: serves read and write requests against per-block sharer slots.
// It invalidates sharers one at a time, waits for each acknowledgement, and
// then grants the request and updates the entry.
// Assumes: acknowledgements arrive only for invalidations this block issued.
// The requester holds req_valid until req_ready is seen.
module lp_dir_ctrl #(
    parameter int NPROC = 16,
    parameter int NPTR  = 2,
    parameter int NBLK  = 16,
    localparam int PID_W  = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int SLOT_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [PID_W-1:0] req_pid,
    input  logic [BLK_W-1:0] req_blk,
    output logic             req_ready,
    output logic             inv_valid,
    output logic [PID_W-1:0] inv_pid,
    output logic [BLK_W-1:0] inv_blk,
    input  logic             ack_valid,
    input  logic [PID_W-1:0] ack_pid,
    output logic             gnt_valid,
    output logic             gnt_write,
    output logic [PID_W-1:0] gnt_pid,
    output logic [BLK_W-1:0] gnt_blk
);
    import lpd_pkg::*;

    eng_state_e        state_q, state_d;
    logic              op_wr_q;
    logic [PID_W-1:0]  pid_q;
    logic [BLK_W-1:0]  blk_q;
    logic [NPTR-1:0]   pend_q, pend_d;
    logic [NPTR-1:0]   kill_q;

    logic [BLK_W-1:0]       rd_blk;
    logic [NPTR*PID_W-1:0]  rd_ptr;
    logic [NPTR-1:0]        rd_vld;
    logic                   rd_dirty, rd_busy;
    logic [PID_W-1:0]       cmp_pid;
    logic [NPTR-1:0]        match, hit_now, vld_after, hit_after;
    logic [NPTR-1:0]        acc_mask;
    logic [SLOT_W-1:0]      victim, cur_slot, free_slot;
    logic                   pend_any, free_any, accept, ack_hit;
    logic                   wr_en, wr_dirty;
    logic [NPTR*PID_W-1:0]  wr_ptr;
    logic [NPTR-1:0]        wr_vld;

    // Read the requested block when idle, otherwise the block in progress.
    assign rd_blk  = (state_q == ST_IDLE) ? req_blk : blk_q;
    assign cmp_pid = (state_q == ST_IDLE) ? req_pid : pid_q;

    lpd_entry_store #(.NBLK(NBLK), .NPTR(NPTR), .PID_W(PID_W), .BLK_W(BLK_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_blk(rd_blk), .rd_ptr(rd_ptr), .rd_vld(rd_vld), .rd_dirty(rd_dirty), .rd_busy(rd_busy),
        .wr_en(wr_en), .wr_blk(blk_q), .wr_ptr(wr_ptr), .wr_vld(wr_vld), .wr_dirty(wr_dirty),
        .set_busy(accept), .clr_busy(wr_en), .busy_blk(rd_blk)
    );

    lpd_lfsr #(.SLOTS(NPTR), .SLOT_W(SLOT_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .victim(victim)
    );

    // Per-slot identifier compare against the current requester.
    for (genvar g = 0; g < NPTR; g++) begin : g_cmp
        assign match[g] = (rd_ptr[g*PID_W +: PID_W] == cmp_pid);
    end
    assign hit_now   = rd_vld & match;
    assign vld_after = rd_vld & ~kill_q;
    assign hit_after = vld_after & match;

    lpd_first_set #(.N(NPTR), .IW(SLOT_W)) u_pend_pick (
        .vec(pend_q), .idx(cur_slot), .any(pend_any)
    );
    lpd_first_set #(.N(NPTR), .IW(SLOT_W)) u_free_pick (
        .vec(~vld_after), .idx(free_slot), .any(free_any)
    );

    // Request handshake: open only when idle and the block is not busy.
    assign req_ready = (state_q == ST_IDLE) && !rd_busy;
    assign accept    = req_valid && req_ready;

    // Invalidation set chosen when a request is accepted.
    always_comb begin
        acc_mask = '0;
        if (req_write) begin
            acc_mask = rd_vld & ~hit_now;
        end else if (rd_dirty && !(|hit_now)) begin
            acc_mask = rd_vld;
        end else if (!(|hit_now) && (&rd_vld)) begin
            acc_mask[victim] = 1'b1;
        end
    end

    // Output pulses derived from the engine state.
    assign inv_valid = (state_q == ST_INV);
    assign inv_pid   = rd_ptr[cur_slot*PID_W +: PID_W];
    assign inv_blk   = blk_q;
    assign gnt_valid = (state_q == ST_GNT);
    assign gnt_write = op_wr_q;
    assign gnt_pid   = pid_q;
    assign gnt_blk   = blk_q;
    assign ack_hit   = ack_valid && (ack_pid == inv_pid);

    // Next-state and pending-mask logic of the transaction engine.
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                pend_d  = acc_mask;
                state_d = (|acc_mask) ? ST_INV : ST_GNT;
            end
            ST_INV:  state_d = ST_WAIT;
            ST_WAIT: if (ack_hit) begin
                pend_d[cur_slot] = 1'b0;
                state_d = (|pend_d) ? ST_INV : ST_GNT;
            end
            ST_GNT:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Engine registers: state, pending slots and the latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            kill_q  <= '0;
            op_wr_q <= 1'b0;
            pid_q   <= '0;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (accept) begin
                kill_q  <= acc_mask;
                op_wr_q <= req_write;
                pid_q   <= req_pid;
                blk_q   <= req_blk;
            end
        end
    end

    // Entry update computed for the grant cycle.
    always_comb begin
        wr_en    = (state_q == ST_GNT);
        wr_ptr   = rd_ptr;
        wr_vld   = vld_after;
        wr_dirty = 1'b0;
        if (op_wr_q) begin
            wr_vld             = '0;
            wr_vld[0]          = 1'b1;
            wr_ptr[PID_W-1:0]  = pid_q;
            wr_dirty           = 1'b1;
        end else if (!(|hit_after) && free_any) begin
            wr_vld[free_slot]                 = 1'b1;
            wr_ptr[free_slot*PID_W +: PID_W]  = pid_q;
        end
    end

    // R4: a clean overflow read opens at most one invalidation.
    a_r4_single_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && !rd_dirty) |=> ($countones(pend_q) <= 1));
    // R5: a grant is issued only once no invalidation remains pending.
    a_r5_grant_clean: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (pend_q == '0));
    // R7: a non-matching acknowledgement keeps the engine waiting.
    a_r7_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !ack_hit) |=> (state_q == ST_WAIT && $stable(pend_q)));
    // R8: a refused request leaves the latched transaction untouched.
    a_r8_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && state_q != ST_IDLE) |=> ($stable(blk_q) && $stable(pid_q)));
endmodule

// File: tb/tb_lp_dir_ctrl.sv
// Bench: directed scenarios, one task each, for the directory controller.
module tb_lp_dir_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [3:0] req_pid = '0, req_blk = '0;
    logic       req_ready;
    logic       inv_valid;
    logic [3:0] inv_pid, inv_blk;
    logic       ack_valid = 1'b0;
    logic [3:0] ack_pid = '0;
    logic       gnt_valid, gnt_write;
    logic [3:0] gnt_pid, gnt_blk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lp_dir_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_pid(req_pid), .req_blk(req_blk),
        .req_ready(req_ready),
        .inv_valid(inv_valid), .inv_pid(inv_pid), .inv_blk(inv_blk),
        .ack_valid(ack_valid), .ack_pid(ack_pid),
        .gnt_valid(gnt_valid), .gnt_write(gnt_write), .gnt_pid(gnt_pid), .gnt_blk(gnt_blk)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Present a request on a falling edge; it is accepted on the next rising edge.
    task automatic send(input bit w, input int pid, input int blk);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_pid = 4'(pid); req_blk = 4'(blk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic exp_gnt(input bit w, input int pid, input int blk, input string req);
        chk(gnt_valid == 1'b1, req, "gnt_valid", int'(gnt_valid), 1);
        chk(inv_valid == 1'b0, req, "inv_valid", int'(inv_valid), 0);
        if (gnt_valid) begin
            chk(gnt_pid == 4'(pid) && gnt_blk == 4'(blk) && gnt_write == w, req, "gnt pid/blk/write",
                int'({gnt_write, gnt_pid, gnt_blk}), int'({w, 4'(pid), 4'(blk)}));
        end
    endtask

    task automatic exp_inv(input int pid, input int blk, input string req);
        chk(inv_valid == 1'b1 && gnt_valid == 1'b0, req, "inv pulse", int'({inv_valid, gnt_valid}), 2);
        chk(inv_pid == 4'(pid) && inv_blk == 4'(blk), req, "inv pid/blk",
            int'({inv_pid, inv_blk}), int'({4'(pid), 4'(blk)}));
    endtask

    // Acknowledge in the waiting cycle; returns on the cycle after the ack edge.
    task automatic ack(input int pid);
        @(negedge clk);
        ack_valid = 1'b1; ack_pid = 4'(pid);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic read_ok(input int pid, input int blk, input string req);
        send(1'b0, pid, blk);
        exp_gnt(1'b0, pid, blk, req);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
        chk(inv_valid == 1'b0, "R1", "inv_valid", int'(inv_valid), 0);
        chk(gnt_valid == 1'b0, "R1", "gnt_valid", int'(gnt_valid), 0);
        read_ok(0, 0, "R1");
    endtask

    task automatic t_read_free();
        read_ok(3, 1, "R2");
        read_ok(5, 1, "R2");
        @(negedge clk);
        chk(gnt_valid == 1'b0, "R2", "single-cycle grant", int'(gnt_valid), 0);
    endtask

    task automatic t_repeat();
        read_ok(1, 2, "R3");
        read_ok(1, 2, "R3");
        read_ok(2, 2, "R3");
    endtask

    task automatic t_overflow();
        int v, s;
        read_ok(1, 3, "R4");
        read_ok(2, 3, "R4");
        send(1'b0, 7, 3);
        v = int'(inv_pid);
        chk(inv_valid && (v == 1 || v == 2), "R4", "victim is a sharer", v, 1);
        s = (v == 1) ? 2 : 1;
        ack(v);
        exp_gnt(1'b0, 7, 3, "R4");
        // A write by a fourth processor must hit exactly the survivor and the new reader.
        send(1'b1, 9, 3);
        v = int'(inv_pid);
        chk(inv_valid && (v == s || v == 7), "R4", "first write inv", v, s);
        ack(v);
        chk(inv_valid && int'(inv_pid) == ((v == 7) ? s : 7), "R4", "second write inv", int'(inv_pid), (v == 7) ? s : 7);
        ack(int'(inv_pid));
        exp_gnt(1'b1, 9, 3, "R5");
    endtask

    task automatic t_write();
        read_ok(1, 4, "R5");
        read_ok(2, 4, "R5");
        send(1'b1, 2, 4);
        exp_inv(1, 4, "R5");
        ack(1);
        exp_gnt(1'b1, 2, 4, "R5");
        send(1'b1, 2, 4);
        exp_gnt(1'b1, 2, 4, "R6");
        send(1'b0, 6, 4);
        exp_inv(2, 4, "R6");
        ack(2);
        exp_gnt(1'b0, 6, 4, "R6");
        send(1'b1, 6, 4);
        exp_gnt(1'b1, 6, 4, "R6");
    endtask

    task automatic t_bad_ack();
        read_ok(1, 5, "R7");
        read_ok(2, 5, "R7");
        send(1'b1, 3, 5);
        exp_inv(1, 5, "R7");
        ack(9);
        chk(!gnt_valid && !inv_valid, "R7", "wrong ack ignored", int'({gnt_valid, inv_valid}), 0);
        ack(1);
        exp_inv(2, 5, "R5");
        ack(2);
        exp_gnt(1'b1, 3, 5, "R5");
    endtask

    task automatic t_busy();
        read_ok(1, 6, "R8");
        send(1'b1, 2, 6);
        exp_inv(1, 6, "R8");
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_pid = 4'd4; req_blk = 4'd7;
        #1;
        chk(req_ready == 1'b0, "R8", "ready while open", int'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        ack(1);
        exp_gnt(1'b1, 2, 6, "R8");
        @(negedge clk);
        chk(!gnt_valid && !inv_valid, "R8", "refused request not served", int'({gnt_valid, inv_valid}), 0);
    endtask

    task automatic t_indep();
        send(1'b1, 1, 8);
        exp_gnt(1'b1, 1, 8, "R10");
        read_ok(2, 9, "R10");
        read_ok(3, 9, "R10");
        send(1'b0, 3, 8);
        exp_inv(1, 8, "R10");
        ack(1);
        exp_gnt(1'b0, 3, 8, "R10");
    endtask

    task automatic t_random();
        int s0, s1, r, v, hit0, hit1;
        s0 = 0; s1 = 1; r = 2; hit0 = 0; hit1 = 0;
        read_ok(s0, 10, "R9");
        read_ok(s1, 10, "R9");
        for (int k = 0; k < 24; k++) begin
            while (r == s0 || r == s1) r = (r + 1) % 16;
            for (int d = 0; d < k % 3; d++) @(negedge clk);
            send(1'b0, r, 10);
            v = int'(inv_pid);
            chk(inv_valid && (v == s0 || v == s1), "R9", "victim is a sharer", v, s0);
            ack(v);
            exp_gnt(1'b0, r, 10, "R9");
            if (v == s0) begin s0 = r; hit0++; end
            else begin s1 = r; hit1++; end
            r = (r + 1) % 16;
        end
        chk(hit0 > 0 && hit1 > 0, "R9", "both slots chosen", hit0 * 100 + hit1, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_free();
        t_repeat();
        t_overflow();
        t_write();
        t_bad_ack();
        t_busy();
        t_indep();
        t_random();
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule